// File: doc/BRIEF.md
# Ethernet MAC Link Configuration Register

This block holds the 32-bit control word through which software sets up an Ethernet MAC's link parameters. It works out the speed and duplex the MAC really runs at by merging the software fields with the PHY link and duplex signals, an automatic speed detector, and the auto-negotiation result. It also produces the receive and transmit pause enables and the VLAN-tagging mode. A self-clearing command bit turns a software write into a single-cycle MAC reset pulse.

Software accesses the register over a minimal bus with an address, a write strobe, write data and combinational read data. The register answers at one parameterized address only. The effective speed is registered and never takes the unused code. The effective duplex is captured only when the link comes up, unless software forces it.

Top module: `mac_link_ctrl`

## Requirements
- R1: The speed field sits at bits 9:8 and is coded 00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s, 11 = unused. After reset the register reads 0x0010_0200, which is speed 10 with bit 20 set. After reset the effective speed output is also 10.
- R2: While `asd_en_i` is high, the effective speed follows `det_speed_i` one clock later. The software speed bits and the force-speed bit (bit 11) have no effect in that state.
- R3: With `asd_en_i` low and bit 11 set, the effective speed equals the software speed bits. With both low, it equals `an_speed_i`. Either way it is updated one clock after the selected source changes.
- R4: If the selected speed source gives code 11, the effective speed keeps its previous value, so code 11 never appears on `eff_speed_o`.
- R5: With force-duplex (bit 12) clear, `eff_fd_o` takes the value of `phy_fdx_i` at the clock edge where `phy_link_i` is first seen high after being low. It holds that value until the next such edge.
- R6: With bit 12 set, `eff_fd_o` equals the software full-duplex bit (bit 0), and the PHY indication is ignored.
- R7: A write with bit 26 set drives `mac_rst_o` high for exactly the one clock that follows the write edge. Bit 26 always reads 0.
- R8: While `an_en_i` is low, bits 27 (receive pause enable) and 28 (transmit pause enable) are written by software and drive `rx_fc_o` and `tx_fc_o`.
- R9: While `an_en_i` is high, a pulse on `an_done_i` loads `an_rx_pause_i` and `an_tx_pause_i` into bits 27 and 28. Software writes to those bits are ignored in that state.
- R10: Only bits 0, 8, 9, 11, 12, 20, 27, 28 and 30 are stored. All other bits read 0 whatever was written. Bit 30 drives `vlan_en_o`, and bit 20 is a plain stored bit that resets to 1.
- R11: Reads at any other address return 0, and writes to any other address leave the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register bus address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| phy_link_i | input | 1 | PHY link-up indication |
| phy_fdx_i | input | 1 | PHY full-duplex indication |
| asd_en_i | input | 1 | Automatic speed detection enable |
| det_speed_i | input | 2 | Detected speed code |
| an_en_i | input | 1 | Auto-negotiation enable |
| an_done_i | input | 1 | Negotiation-complete strobe |
| an_speed_i | input | 2 | Negotiated speed code |
| an_rx_pause_i | input | 1 | Negotiated receive pause result |
| an_tx_pause_i | input | 1 | Negotiated transmit pause result |
| eff_speed_o | output | 2 | Effective MAC speed code |
| eff_fd_o | output | 1 | Effective full-duplex |
| rx_fc_o | output | 1 | Receive flow-control enable |
| tx_fc_o | output | 1 | Transmit flow-control enable |
| vlan_en_o | output | 1 | VLAN mode enable |
| mac_rst_o | output | 1 | Single-cycle MAC reset pulse |

## Verification
Speed resolution is tried under three settings: detection on, force on, and neither. In each setting the other two sources carry values that differ from the selected one, so a wrong priority shows up as a wrong code. Each source is also fed code 11 to show that the previous speed is held.

Duplex is tested with the PHY duplex signal toggling while the link is held up and while it is down. This separates capture on the link's rising edge from a plain level-sensitive follow. Force-duplex is then set and cleared to show that the latched PHY value survives the override.

The pause enables are written with negotiation off and then with negotiation on. This shows that software writes are blocked only while negotiation is on. An all-ones write followed by a read-back exposes any reserved bit that is stored.

// File: rtl/mac_link_ctrl_pkg.sv
package mac_link_ctrl_pkg;
  localparam int unsigned REG_W = 32;

  localparam int unsigned B_FD      = 0;
  localparam int unsigned B_SPD_LO  = 8;
  localparam int unsigned B_SPD_HI  = 9;
  localparam int unsigned B_FRC_SPD = 11;
  localparam int unsigned B_FRC_DPX = 12;
  localparam int unsigned B_WAKE    = 20;
  localparam int unsigned B_MRST    = 26;
  localparam int unsigned B_RXFC    = 27;
  localparam int unsigned B_TXFC    = 28;
  localparam int unsigned B_VLAN    = 30;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_BAD  = 2'b11
  } speed_e;

  localparam int unsigned N_FC = 2; // index 0 = rx, 1 = tx
endpackage

// File: rtl/mac_ctrl_fields.sv
module mac_ctrl_fields
  import mac_link_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] spd_d_i,
  input  logic       frc_spd_d_i,
  input  logic       frc_dpx_d_i,
  input  logic       fd_d_i,
  input  logic       wake_d_i,
  input  logic       vlan_d_i,
  input  logic       mrst_d_i,
  output logic [1:0] spd_o,
  output logic       frc_spd_o,
  output logic       frc_dpx_o,
  output logic       fd_o,
  output logic       wake_o,
  output logic       vlan_o,
  output logic       mrst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spd_o     <= SPD_1000;
      frc_spd_o <= 1'b0;
      frc_dpx_o <= 1'b0;
      fd_o      <= 1'b0;
      wake_o    <= 1'b1;
      vlan_o    <= 1'b0;
      mrst_o    <= 1'b0;
    end else begin
      mrst_o <= wr_i & mrst_d_i; // self-clearing command
      if (wr_i) begin
        spd_o     <= spd_d_i;
        frc_spd_o <= frc_spd_d_i;
        frc_dpx_o <= frc_dpx_d_i;
        fd_o      <= fd_d_i;
        wake_o    <= wake_d_i;
        vlan_o    <= vlan_d_i;
      end
    end
  end
endmodule

// File: rtl/mac_speed_resolve.sv
module mac_speed_resolve
  import mac_link_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       asd_en_i,
  input  logic [1:0] det_speed_i,
  input  logic       frc_spd_i,
  input  logic [1:0] sw_speed_i,
  input  logic [1:0] an_speed_i,
  output logic [1:0] eff_speed_o
);
  logic [1:0] cand;

  always_comb begin
    if (asd_en_i)       cand = det_speed_i;
    else if (frc_spd_i) cand = sw_speed_i;
    else                cand = an_speed_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                eff_speed_o <= SPD_1000;
    else if (cand != SPD_BAD)   eff_speed_o <= cand;
  end
endmodule

// File: rtl/mac_duplex_track.sv
module mac_duplex_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic phy_link_i,
  input  logic phy_fdx_i,
  input  logic frc_dpx_i,
  input  logic sw_fd_i,
  output logic eff_fd_o
);
  logic link_q;
  logic fd_lat_q;
  logic link_rise;

  assign link_rise = phy_link_i & ~link_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q   <= 1'b0;
      fd_lat_q <= 1'b0;
    end else begin
      link_q <= phy_link_i;
      if (link_rise) fd_lat_q <= phy_fdx_i;
    end
  end

  assign eff_fd_o = frc_dpx_i ? sw_fd_i : fd_lat_q;
endmodule

// File: rtl/mac_fc_ctrl.sv
module mac_fc_ctrl #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] sw_d_i,
  input  logic         an_en_i,
  input  logic         an_done_i,
  input  logic [N-1:0] an_res_i,
  output logic [N-1:0] fc_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                    fc_o[g] <= 1'b0;
      else if (an_en_i && an_done_i)  fc_o[g] <= an_res_i[g];
      else if (!an_en_i && wr_i)      fc_o[g] <= sw_d_i[g];
    end
  end
endmodule

// File: rtl/mac_link_ctrl.sv
module mac_link_ctrl
  import mac_link_ctrl_pkg::*;
#(
  parameter int unsigned        ADDR_W    = 8,
  parameter logic [ADDR_W-1:0]  CTRL_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              phy_link_i,
  input  logic              phy_fdx_i,
  input  logic              asd_en_i,
  input  logic [1:0]        det_speed_i,
  input  logic              an_en_i,
  input  logic              an_done_i,
  input  logic [1:0]        an_speed_i,
  input  logic              an_rx_pause_i,
  input  logic              an_tx_pause_i,
  output logic [1:0]        eff_speed_o,
  output logic              eff_fd_o,
  output logic              rx_fc_o,
  output logic              tx_fc_o,
  output logic              vlan_en_o,
  output logic              mac_rst_o
);
  logic             hit;
  logic             wr_hit;
  logic [1:0]       sw_spd;
  logic             frc_spd, frc_dpx, sw_fd, wake;
  logic [N_FC-1:0]  fc_q;
  logic [REG_W-1:0] rd_word;
  logic             unused_wdata;

  assign hit          = (addr_i == CTRL_ADDR);
  assign wr_hit       = we_i & hit;
  assign unused_wdata = ^wdata_i;

  mac_ctrl_fields u_fields (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_hit),
    .spd_d_i     (wdata_i[B_SPD_HI:B_SPD_LO]),
    .frc_spd_d_i (wdata_i[B_FRC_SPD]),
    .frc_dpx_d_i (wdata_i[B_FRC_DPX]),
    .fd_d_i      (wdata_i[B_FD]),
    .wake_d_i    (wdata_i[B_WAKE]),
    .vlan_d_i    (wdata_i[B_VLAN]),
    .mrst_d_i    (wdata_i[B_MRST]),
    .spd_o       (sw_spd),
    .frc_spd_o   (frc_spd),
    .frc_dpx_o   (frc_dpx),
    .fd_o        (sw_fd),
    .wake_o      (wake),
    .vlan_o      (vlan_en_o),
    .mrst_o      (mac_rst_o)
  );

  mac_speed_resolve u_speed (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .asd_en_i    (asd_en_i),
    .det_speed_i (det_speed_i),
    .frc_spd_i   (frc_spd),
    .sw_speed_i  (sw_spd),
    .an_speed_i  (an_speed_i),
    .eff_speed_o (eff_speed_o)
  );

  mac_duplex_track u_dpx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phy_link_i (phy_link_i),
    .phy_fdx_i  (phy_fdx_i),
    .frc_dpx_i  (frc_dpx),
    .sw_fd_i    (sw_fd),
    .eff_fd_o   (eff_fd_o)
  );

  mac_fc_ctrl #(.N(N_FC)) u_fc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_hit),
    .sw_d_i    ({wdata_i[B_TXFC], wdata_i[B_RXFC]}),
    .an_en_i   (an_en_i),
    .an_done_i (an_done_i),
    .an_res_i  ({an_tx_pause_i, an_rx_pause_i}),
    .fc_o      (fc_q)
  );

  assign rx_fc_o = fc_q[0];
  assign tx_fc_o = fc_q[1];

  always_comb begin
    rd_word                    = '0;
    rd_word[B_FD]              = sw_fd;
    rd_word[B_SPD_HI:B_SPD_LO] = sw_spd;
    rd_word[B_FRC_SPD]         = frc_spd;
    rd_word[B_FRC_DPX]         = frc_dpx;
    rd_word[B_WAKE]            = wake;
    rd_word[B_RXFC]            = fc_q[0];
    rd_word[B_TXFC]            = fc_q[1];
    rd_word[B_VLAN]            = vlan_en_o;
  end

  assign rdata_o = hit ? rd_word : '0;
endmodule

// File: rtl/mac_link_ctrl_chk.sv
module mac_link_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_hit,
  input logic [31:0] wdata_i,
  input logic        mac_rst_o,
  input logic [1:0]  eff_speed_o,
  input logic        asd_en_i,
  input logic [1:0]  det_speed_i,
  input logic        an_en_i,
  input logic        an_done_i,
  input logic        an_rx_pause_i,
  input logic        an_tx_pause_i,
  input logic        rx_fc_o,
  input logic        tx_fc_o
);
  assert_rst_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && wdata_i[26]) |=> mac_rst_o);

  assert_rst_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_hit && wdata_i[26]) |=> !mac_rst_o);

  assert_no_bad_speed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_speed_o != 2'b11);

  assert_asd_follow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (asd_en_i && det_speed_i != 2'b11) |=> eff_speed_o == $past(det_speed_i));

  assert_an_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_en_i && an_done_i) |=> (rx_fc_o == $past(an_rx_pause_i)) && (tx_fc_o == $past(an_tx_pause_i)));

  assert_fc_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_en_i && !an_done_i) |=> $stable(rx_fc_o) && $stable(tx_fc_o));
endmodule

bind mac_link_ctrl mac_link_ctrl_chk u_chk (.*);

// File: tb/mac_link_ctrl_tb.sv
module mac_link_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        link = 1'b0, fdx = 1'b0, asd = 1'b0, an_en = 1'b0, an_done = 1'b0;
  logic [1:0]  det = 2'b00, an_spd = 2'b10;
  logic        an_rx = 1'b0, an_tx = 1'b0;
  logic [1:0]  eff_spd;
  logic        eff_fd, rx_fc, tx_fc, vlan, mrst;
  int          n_run = 0, n_fail = 0;
  bit          finished = 0;

  always #5 clk = ~clk;

  mac_link_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .phy_link_i(link), .phy_fdx_i(fdx), .asd_en_i(asd),
    .det_speed_i(det), .an_en_i(an_en), .an_done_i(an_done), .an_speed_i(an_spd),
    .an_rx_pause_i(an_rx), .an_tx_pause_i(an_tx), .eff_speed_o(eff_spd),
    .eff_fd_o(eff_fd), .rx_fc_o(rx_fc), .tx_fc_o(tx_fc), .vlan_en_o(vlan),
    .mac_rst_o(mrst)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0; addr = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata; addr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h00, v);
    check("R1 reset word", v, 32'h0010_0200);
    check("R1 reset speed", eff_spd, 2'b10);
    check("R5 reset duplex", eff_fd, 0);
    check("R7 reset pulse", mrst, 0);
    check("R8 reset fc", {rx_fc, tx_fc}, 0);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v);
    check("R10 stored bits", v, 32'h5810_1B01);
    check("R10 vlan out", vlan, 1);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, v);
    check("R10 clear all", v, 0);
    check("R10 vlan off", vlan, 0);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, v);
    check("R11 other-addr write ignored", v, 0);
    rd(8'h04, v);
    check("R11 other-addr read", v, 0);
  endtask

  task automatic t_speed();
    // force sw speed 01, no detect
    wr(8'h00, 32'h0000_0900); tick();
    check("R3 forced sw speed", eff_spd, 2'b01);
    wr(8'h00, 32'h0000_0100); tick();
    check("R3 negotiated speed", eff_spd, 2'b10);
    an_spd = 2'b00; tick(); tick();
    check("R3 negotiated follows", eff_spd, 2'b00);
    asd = 1'b1; det = 2'b01; tick();
    check("R2 detected speed", eff_spd, 2'b01);
    wr(8'h00, 32'h0000_0A00); tick();
    check("R2 sw bits ignored", eff_spd, 2'b01);
    det = 2'b11; tick(); tick();
    check("R4 bad detect holds", eff_spd, 2'b01);
    asd = 1'b0; det = 2'b00; tick(); tick();
    check("R3 forced after detect off", eff_spd, 2'b10);
    wr(8'h00, 32'h0000_0B00); tick();
    check("R4 bad sw code holds", eff_spd, 2'b10);
    an_spd = 2'b11; wr(8'h00, 32'h0); tick();
    check("R4 bad negotiated holds", eff_spd, 2'b10);
    an_spd = 2'b10;
  endtask

  task automatic t_duplex();
    link = 1'b0; fdx = 1'b1; tick();
    check("R5 no edge yet", eff_fd, 0);
    link = 1'b1; tick();
    check("R5 captured on rise", eff_fd, 1);
    fdx = 1'b0; tick(); tick();
    check("R5 held while up", eff_fd, 1);
    link = 1'b0; tick();
    check("R5 held while down", eff_fd, 1);
    link = 1'b1; tick();
    check("R5 recaptured", eff_fd, 0);
    fdx = 1'b1;
    wr(8'h00, 32'h0000_1001);
    check("R6 forced full", eff_fd, 1);
    fdx = 1'b0;
    wr(8'h00, 32'h0000_1000);
    check("R6 forced half", eff_fd, 0);
    fdx = 1'b1; tick();
    wr(8'h00, 32'h0000_1001);
    wr(8'h00, 32'h0000_0000);
    check("R6 latched value after release", eff_fd, 0);
  endtask

  task automatic t_rst_pulse();
    logic [31:0] v;
    check("R7 idle", mrst, 0);
    wr(8'h00, 32'h0400_0000);
    check("R7 pulse high", mrst, 1);
    tick();
    check("R7 pulse one cycle", mrst, 0);
    rd(8'h00, v);
    check("R7 bit reads zero", v[26], 0);
    wr(8'h04, 32'h0400_0000);
    check("R11 no pulse other addr", mrst, 0);
  endtask

  task automatic t_fc();
    logic [31:0] v;
    an_en = 1'b0;
    wr(8'h00, 32'h1800_0000);
    check("R8 both enabled", {rx_fc, tx_fc}, 2'b11);
    wr(8'h00, 32'h0800_0000);
    check("R8 rx only", {rx_fc, tx_fc}, 2'b10);
    an_en = 1'b1; an_rx = 1'b0; an_tx = 1'b1; tick();
    check("R9 no load without strobe", {rx_fc, tx_fc}, 2'b10);
    an_done = 1'b1; tick(); an_done = 1'b0;
    check("R9 loaded from negotiation", {rx_fc, tx_fc}, 2'b01);
    wr(8'h00, 32'h1800_0000);
    check("R9 write ignored", {rx_fc, tx_fc}, 2'b01);
    rd(8'h00, v);
    check("R9 readback", v & 32'h1800_0000, 32'h1000_0000);
    an_en = 1'b0;
    wr(8'h00, 32'h0000_0000);
    check("R8 writable again", {rx_fc, tx_fc}, 2'b00);
  endtask

  initial begin
    #95_000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask();
    t_speed();
    t_duplex();
    t_rst_pulse();
    t_fc();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule